// File: doc/BRIEF.md
# Sound Generator Host Register Interface

This block is the host-facing side of a three-channel programmable sound generator. The host drives a two-wire control code and an 8-bit data bus. Depending on the code, the block latches a register address, writes the addressed register, reads it back, or does nothing. Sixteen 8-bit registers hold the tone periods, the noise period, the mixer enables, the channel amplitudes, the envelope period and shape, and two general-purpose 8-bit ports.

The block passes decoded fields to the tone, noise and envelope generators next to it. A period of zero is presented as one. After every accepted write it raises a single-cycle strobe together with the register index. A write to the envelope-shape register also raises a restart pulse. Bits 6 and 7 of the mixer register set the direction of each port. A port in input mode captures its external pins whenever the host reads it.

Top module: `psg_regif`

## Requirements
- R1: After reset (rst_ni low) every register and the address latch are zero. The outputs then show port output-enables 0, port values 0, tone/noise/envelope periods 1, all disables 0, and amplitudes 0.
- R2: The control code {bdir_i,bc1_i} means: 11 latch data_i as address, 10 write data_i to the latched register, 01 read, 00 idle. A write stores data_i AND a per-index mask. The masks are 0xFF for indices 0,2,4,7,11,12,14,15; 0x0F for 1,3,5,13; and 0x1F for 6,8,9,10.
- R3: All eight latched address bits are compared. A latched address of 16 or more causes no register change and no write strobe, and a read at such an address returns 0.
- R4: rdata_o shows the addressed register only while the read code 01 is applied, and is 0 at every other time.
- R5: One cycle after an accepted write edge, wr_stb_o is 1 for one cycle and wr_idx_o holds the written index.
- R6: env_restart_o pulses together with wr_stb_o only when the written index is 13. env_shape_o gives bits 3:0 of register 13.
- R7: tone_dis_o[i] is register 7 bit i, and noise_dis_o[i] is register 7 bit 3+i, for channels i=0..2. A 1 means disabled.
- R8: porta_oe_o is register 7 bit 6 and portb_oe_o is bit 7. porta_o and portb_o show registers 14 and 15. When a port is in input mode (bit 0), reading its register returns the pin value and stores it in the register. In output mode a read returns the register content.
- R9: For channel i, amp_lvl_o[4i+3:4i] is bits 3:0 of register 8+i, and amp_env_o[i] is bit 4 of that register.
- R10: The tone period of channel i is {register 2i+1 bits 3:0, register 2i}. The noise period is register 6 bits 4:0. The envelope period is {register 12, register 11}. Each of these is shown as 1 when its value is 0.
- R11: The address latch keeps its value across accesses, so a sequence of writes and reads without a new latch all target the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bdir_i | input | 1 | Bus control, upper code bit |
| bc1_i | input | 1 | Bus control, lower code bit |
| data_i | input | 8 | Host data / address bus |
| rdata_o | output | 8 | Read data, 0 when not reading |
| porta_i | input | 8 | Port A external pins |
| portb_i | input | 8 | Port B external pins |
| porta_o | output | 8 | Port A register value |
| portb_o | output | 8 | Port B register value |
| porta_oe_o | output | 1 | Port A output mode |
| portb_oe_o | output | 1 | Port B output mode |
| wr_stb_o | output | 1 | Register written strobe |
| wr_idx_o | output | 4 | Index of written register |
| env_restart_o | output | 1 | Envelope shape written |
| tone_per_o | output | 36 | Three 12-bit tone periods, channel 0 in low bits |
| noise_per_o | output | 5 | Noise period |
| tone_dis_o | output | 3 | Tone disable per channel |
| noise_dis_o | output | 3 | Noise disable per channel |
| amp_lvl_o | output | 12 | Three 4-bit fixed levels |
| amp_env_o | output | 3 | Envelope-level select per channel |
| env_per_o | output | 16 | Envelope period |
| env_shape_o | output | 4 | Envelope shape bits |

## Verification
The assertions assume that the control code is stable across each clock edge, and that a latch always comes before the first write or read after reset. Under these assumptions the write strobe can be traced to the write code one cycle earlier, and the port directions change only on a write. The bench drives every input on the falling edge and starts every access with its own latch. The port pins change only while no read code is applied, so each captured value is known.

// File: rtl/psg_regif_pkg.sv
package psg_regif_pkg;
  localparam int DW   = 8;
  localparam int NREG = 16;
  localparam int IW   = $clog2(NREG);
  localparam int NCH  = 3;
  localparam int TPW  = 12;
  localparam int NPW  = 5;
  localparam int LVW  = 4;
  localparam int EPW  = 2 * DW;
  localparam int SHW  = 4;

  localparam int IDX_NOISE = 6;
  localparam int IDX_MIX   = 7;
  localparam int IDX_AMP0  = 8;
  localparam int IDX_ENVLO = 11;
  localparam int IDX_ENVHI = 12;
  localparam int IDX_SHAPE = 13;
  localparam int IDX_PORT0 = 14;

  // code is {bdir, bc1}
  typedef enum logic [1:0] {
    BUS_IDLE  = 2'b00,
    BUS_READ  = 2'b01,
    BUS_WRITE = 2'b10,
    BUS_LATCH = 2'b11
  } bus_op_e;

  function automatic logic [DW-1:0] wr_mask(input int idx);
    if (idx < 2 * NCH)                     return idx[0] ? 8'h0F : 8'hFF;
    if (idx == IDX_NOISE)                  return 8'h1F;
    if (idx >= IDX_AMP0 && idx < IDX_AMP0 + NCH) return 8'h1F;
    if (idx == IDX_SHAPE)                  return 8'h0F;
    return 8'hFF;
  endfunction
endpackage

// File: rtl/psg_bus_decode.sv
module psg_bus_decode
  import psg_regif_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bdir_i,
  input  logic          bc1_i,
  input  logic [DW-1:0] data_i,
  output bus_op_e       op_o,
  output logic          addr_ok_o,
  output logic [IW-1:0] idx_o
);
  logic [DW-1:0] addr_q;

  assign op_o = bus_op_e'({bdir_i, bc1_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               addr_q <= '0;
    else if (op_o == BUS_LATCH) addr_q <= data_i;
  end

  // full address compared; upper bits act as chip select
  assign addr_ok_o = (addr_q < DW'(NREG));
  assign idx_o     = addr_q[IW-1:0];
endmodule

// File: rtl/psg_reg_bank.sv
module psg_reg_bank
  import psg_regif_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  bus_op_e                  op_i,
  input  logic                     addr_ok_i,
  input  logic [IW-1:0]            idx_i,
  input  logic [DW-1:0]            data_i,
  input  logic [1:0][DW-1:0]       pins_i,
  output logic [NREG-1:0][DW-1:0]  regs_o,
  output logic [DW-1:0]            rdata_o,
  output logic                     wr_stb_o,
  output logic [IW-1:0]            wr_idx_o
);
  logic [NREG-1:0][DW-1:0] regs_q;
  logic wr_hit, rd_hit;

  assign wr_hit = (op_i == BUS_WRITE) && addr_ok_i;
  assign rd_hit = (op_i == BUS_READ)  && addr_ok_i;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] MASK = wr_mask(g);
    if (g >= IDX_PORT0) begin : g_port
      logic in_mode;
      assign in_mode = ~regs_q[IDX_MIX][6 + g - IDX_PORT0];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          regs_q[g] <= '0;
        else if (wr_hit && idx_i == IW'(g))
          regs_q[g] <= data_i & MASK;
        else if (rd_hit && idx_i == IW'(g) && in_mode)
          regs_q[g] <= pins_i[g - IDX_PORT0];
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        regs_q[g] <= '0;
        else if (wr_hit && idx_i == IW'(g)) regs_q[g] <= data_i & MASK;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_hit) begin
      rdata_o = regs_q[idx_i];
      if (idx_i >= IW'(IDX_PORT0) && !regs_q[IDX_MIX][6 + 32'(idx_i - IW'(IDX_PORT0))])
        rdata_o = pins_i[idx_i - IW'(IDX_PORT0)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_stb_o <= 1'b0;
      wr_idx_o <= '0;
    end else begin
      wr_stb_o <= wr_hit;
      if (wr_hit) wr_idx_o <= idx_i;
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/psg_field_export.sv
module psg_field_export
  import psg_regif_pkg::*;
(
  input  logic [NREG-1:0][DW-1:0] regs_i,
  output logic [NCH*TPW-1:0]      tone_per_o,
  output logic [NPW-1:0]          noise_per_o,
  output logic [NCH-1:0]          tone_dis_o,
  output logic [NCH-1:0]          noise_dis_o,
  output logic [NCH*LVW-1:0]      amp_lvl_o,
  output logic [NCH-1:0]          amp_env_o,
  output logic [EPW-1:0]          env_per_o,
  output logic [SHW-1:0]          env_shape_o,
  output logic [1:0]              port_oe_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [TPW-1:0] raw;
    assign raw = {regs_i[2*c+1][TPW-DW-1:0], regs_i[2*c]};
    assign tone_per_o[c*TPW +: TPW] = (raw == '0) ? TPW'(1) : raw;
    assign tone_dis_o[c]            = regs_i[IDX_MIX][c];
    assign noise_dis_o[c]           = regs_i[IDX_MIX][NCH + c];
    assign amp_lvl_o[c*LVW +: LVW]  = regs_i[IDX_AMP0 + c][LVW-1:0];
    assign amp_env_o[c]             = regs_i[IDX_AMP0 + c][LVW];
  end

  logic [EPW-1:0] env_raw;
  assign env_raw     = {regs_i[IDX_ENVHI], regs_i[IDX_ENVLO]};
  assign env_per_o   = (env_raw == '0) ? EPW'(1) : env_raw;
  assign noise_per_o = (regs_i[IDX_NOISE][NPW-1:0] == '0) ? NPW'(1)
                                                         : regs_i[IDX_NOISE][NPW-1:0];
  assign env_shape_o = regs_i[IDX_SHAPE][SHW-1:0];
  assign port_oe_o   = regs_i[IDX_MIX][7:6];
endmodule

// File: rtl/psg_regif.sv
module psg_regif
  import psg_regif_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bdir_i,
  input  logic               bc1_i,
  input  logic [7:0]         data_i,
  output logic [7:0]         rdata_o,
  input  logic [7:0]         porta_i,
  input  logic [7:0]         portb_i,
  output logic [7:0]         porta_o,
  output logic [7:0]         portb_o,
  output logic               porta_oe_o,
  output logic               portb_oe_o,
  output logic               wr_stb_o,
  output logic [3:0]         wr_idx_o,
  output logic               env_restart_o,
  output logic [35:0]        tone_per_o,
  output logic [4:0]         noise_per_o,
  output logic [2:0]         tone_dis_o,
  output logic [2:0]         noise_dis_o,
  output logic [11:0]        amp_lvl_o,
  output logic [2:0]         amp_env_o,
  output logic [15:0]        env_per_o,
  output logic [3:0]         env_shape_o
);
  bus_op_e                 op;
  logic                    addr_ok;
  logic [IW-1:0]           idx;
  logic [NREG-1:0][DW-1:0] regs;
  logic [1:0]              port_oe;

  psg_bus_decode u_dec (
    .clk_i, .rst_ni, .bdir_i, .bc1_i, .data_i,
    .op_o(op), .addr_ok_o(addr_ok), .idx_o(idx)
  );

  psg_reg_bank u_bank (
    .clk_i, .rst_ni, .op_i(op), .addr_ok_i(addr_ok), .idx_i(idx), .data_i,
    .pins_i({portb_i, porta_i}), .regs_o(regs), .rdata_o,
    .wr_stb_o, .wr_idx_o
  );

  psg_field_export u_fld (
    .regs_i(regs), .tone_per_o, .noise_per_o, .tone_dis_o, .noise_dis_o,
    .amp_lvl_o, .amp_env_o, .env_per_o, .env_shape_o, .port_oe_o(port_oe)
  );

  assign porta_o       = regs[IDX_PORT0];
  assign portb_o       = regs[IDX_PORT0 + 1];
  assign porta_oe_o    = port_oe[0];
  assign portb_oe_o    = port_oe[1];
  assign env_restart_o = wr_stb_o && (wr_idx_o == IW'(IDX_SHAPE));
endmodule

// File: rtl/psg_regif_chk.sv
module psg_regif_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bdir_i,
  input logic        bc1_i,
  input logic [7:0]  rdata_o,
  input logic        porta_oe_o,
  input logic        portb_oe_o,
  input logic        wr_stb_o,
  input logic [3:0]  wr_idx_o,
  input logic        env_restart_o,
  input logic [35:0] tone_per_o,
  input logic [4:0]  noise_per_o,
  input logic [15:0] env_per_o
);
  // R4
  rdata_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!bdir_i && bc1_i) |-> rdata_o == 8'h00);

  // R5
  wr_stb_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(bdir_i && !bc1_i));

  // R6
  env_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    env_restart_o |-> (wr_stb_o && wr_idx_o == 4'd13));

  // R8
  port_dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bdir_i && !bc1_i) |-> ($stable(porta_oe_o) && $stable(portb_oe_o)));

  // R10
  period_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_per_o[11:0] != 0 && tone_per_o[23:12] != 0 && tone_per_o[35:24] != 0 &&
    noise_per_o != 0 && env_per_o != 0);
endmodule

bind psg_regif psg_regif_chk u_chk (.*);

// File: tb/tb_psg_regif.sv
module tb_psg_regif;
  logic clk_i = 1'b0, rst_ni = 1'b0, bdir_i = 1'b0, bc1_i = 1'b0;
  logic [7:0] data_i = '0, porta_i = '0, portb_i = '0;
  logic [7:0] rdata_o, porta_o, portb_o;
  logic porta_oe_o, portb_oe_o, wr_stb_o, env_restart_o;
  logic [3:0] wr_idx_o, env_shape_o;
  logic [35:0] tone_per_o;
  logic [4:0] noise_per_o;
  logic [2:0] tone_dis_o, noise_dis_o, amp_env_o;
  logic [11:0] amp_lvl_o;
  logic [15:0] env_per_o;
  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  psg_regif dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input int i);
    case (i)
      1, 3, 5, 13: return 8'h0F;
      6, 8, 9, 10: return 8'h1F;
      default:     return 8'hFF;
    endcase
  endfunction

  task automatic latch(input logic [7:0] a);
    @(negedge clk_i); bdir_i = 1; bc1_i = 1; data_i = a;
  endtask

  task automatic wr_nolatch(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i); bdir_i = 1; bc1_i = 0; data_i = d;
    @(negedge clk_i); bdir_i = 0; bc1_i = 0;
    chk("R5 stb", wr_stb_o, a < 16);
    if (a < 16) chk("R5 idx", wr_idx_o, a[3:0]);
    chk("R6 restart", env_restart_o, a == 13);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    latch(a); wr_nolatch(a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    latch(a);
    @(negedge clk_i); bdir_i = 0; bc1_i = 1;
    #1 v = rdata_o;
    @(negedge clk_i); bdir_i = 0; bc1_i = 0;
    #1 chk("R4 idle zero", rdata_o, 8'h00);
  endtask

  task automatic t_reset();
    chk("R1 oe", {porta_oe_o, portb_oe_o}, 2'b00);
    chk("R1 ports", {porta_o, portb_o}, 16'h0);
    chk("R1 tone per", tone_per_o, {12'd1, 12'd1, 12'd1});
    chk("R1 noise/env per", {noise_per_o, env_per_o}, {5'd1, 16'd1});
    chk("R1 dis", {tone_dis_o, noise_dis_o}, 6'b0);
    chk("R1 amp", {amp_lvl_o, amp_env_o}, 15'b0);
    chk("R1 stb", wr_stb_o, 1'b0);
  endtask

  task automatic t_masks();
    logic [7:0] v;
    for (int i = 0; i < 16; i++) wr(8'(i), 8'hFF);
    for (int i = 0; i < 16; i++) begin
      rd(8'(i), v);
      chk($sformatf("R2 mask idx %0d", i), v, mask_of(i));
    end
  endtask

  task automatic t_range();
    logic [7:0] v;
    wr(8'h10, 8'h00);
    wr(8'h20, 8'h00);
    wr(8'hF3, 8'h00);
    rd(8'h00, v); chk("R3 reg0 kept", v, 8'hFF);
    rd(8'h03, v); chk("R3 reg3 kept", v, 8'h0F);
    rd(8'h10, v); chk("R3 read oob", v, 8'h00);
  endtask

  task automatic t_periods();
    wr(0, 8'h00); wr(1, 8'h00);
    wr(2, 8'h34); wr(3, 8'hF2);
    wr(4, 8'hAB); wr(5, 8'h01);
    chk("R10 tone0 zero->1", tone_per_o[11:0], 12'd1);
    chk("R10 tone1", tone_per_o[23:12], 12'h234);
    chk("R10 tone2", tone_per_o[35:24], 12'h1AB);
    wr(6, 8'hE0); chk("R10 noise zero->1", noise_per_o, 5'd1);
    wr(6, 8'hF3); chk("R10 noise", noise_per_o, 5'h13);
    wr(11, 0); wr(12, 0); chk("R10 env zero->1", env_per_o, 16'd1);
    wr(11, 8'h12); wr(12, 8'h34); chk("R10 env", env_per_o, 16'h3412);
  endtask

  task automatic t_mix_amp();
    wr(7, 8'h2A);
    chk("R7 tone dis", tone_dis_o, 3'b010);
    chk("R7 noise dis", noise_dis_o, 3'b101);
    wr(8, 8'h1F); wr(9, 8'h07); wr(10, 8'hE3);
    chk("R9 levels", amp_lvl_o, {4'h3, 4'h7, 4'hF});
    chk("R9 env sel", amp_env_o, 3'b001);
    wr(13, 8'hFA);
    chk("R6 shape", env_shape_o, 4'hA);
  endtask

  task automatic t_ports();
    logic [7:0] v;
    wr(7, 8'h00);
    chk("R8 oe input", {porta_oe_o, portb_oe_o}, 2'b00);
    porta_i = 8'hA5; portb_i = 8'h3C;
    rd(14, v); chk("R8 pins A", v, 8'hA5);
    rd(15, v); chk("R8 pins B", v, 8'h3C);
    porta_i = 8'h11;
    wr(7, 8'h40);
    chk("R8 oe A only", {porta_oe_o, portb_oe_o}, 2'b10);
    chk("R8 captured A", porta_o, 8'hA5);
    rd(14, v); chk("R8 output read reg", v, 8'hA5);
    wr(14, 8'h77); chk("R8 out value", porta_o, 8'h77);
    wr(7, 8'h80);
    chk("R8 oe B only", {porta_oe_o, portb_oe_o}, 2'b01);
    chk("R8 captured B", portb_o, 8'h3C);
  endtask

  task automatic t_latch_hold();
    logic [7:0] v;
    latch(8'h02);
    wr_nolatch(8'h02, 8'h11);
    wr_nolatch(8'h02, 8'h22);
    rd(8'h02, v); chk("R11 latch held", v, 8'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1 t_reset();
    rst_ni = 1;
    t_masks();
    t_range();
    t_periods();
    t_mix_amp();
    t_ports();
    t_latch_hold();
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule